// File: doc/BRIEF.md
# EEPROM Software Write-Protection Sequencer

This block models the protection logic of a byte-wide parallel EEPROM. It watches every write strobe, together with the 15-bit address and the 8-bit data that come with it. It looks for two command sequences. One sequence turns software protection on and the other turns it off. A single protect flag gates the writes that reach a small internal byte array. While the flag is set, ordinary writes are dropped. While the flag is clear, ordinary writes go through to the array. Reads are combinational and always show the stored byte.

Both sequences begin with the same two writes: 0xAA to address 0x5555, then 0x55 to address 0x2AAA. The third write decides which sequence is running:
- 0xA0 to 0x5555 completes the lock.
- 0x80 to 0x5555 continues the unlock, which then needs 0xAA to 0x5555, 0x55 to 0x2AAA and finally 0x20 to 0x5555.

A write that does not match the next expected step ends the partial sequence and is treated as an ordinary write. Reset models a part shipped from the factory: it comes up locked.

The array holds 2^MEM_AW bytes and is indexed by the low MEM_AW address bits, so higher addresses alias onto it.

Top module: `eeprom_sdp_guard`

## Requirements
- R1: Reset sets the protect flag (protect_on = 1), fills every array byte with 0xFF and returns the sequence detector to idle, so a sequence begun before reset cannot complete after it.
- R2: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555, issued in that order, clear protect_on on the clock edge of the sixth write.
- R3: The three writes 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555, issued in that order, set protect_on on the clock edge of the third write.
- R4: While protect_on is 1, an ordinary write leaves every array byte unchanged.
- R5: While protect_on is 0, an ordinary write stores wdata at array index addr[MEM_AW-1:0] on its clock edge.
- R6: A write that matches the next step of a sequence never changes the array, whatever the state of the protect flag.
- R7: A write whose address or data does not match the next expected step returns the detector to idle and is handled as an ordinary write. A repeated 0xAA@0x5555 after the first step counts as such a mismatch.
- R8: After the shared two-step prefix, 0x80@0x5555 leaves the flag unchanged and waits for the unlock tail. A mismatch after that point aborts without changing the flag.
- R9: With wr_en low, neither the flag nor the array changes, whatever addr and wdata do.
- R10: rdata always equals the array byte at index addr[MEM_AW-1:0], with no clock delay. Addresses that differ only above bit MEM_AW-1 read the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| addr | input | 15 | Device address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Array byte at the low address bits (combinational) |
| protect_on | output | 1 | Current protect flag (1 = writes refused) |

## Verification
The bench checks that a correct write following a wrong one does not resume the sequence. It also checks that a second 0xAA@0x5555 restarts nothing: a detector that re-armed on it would later take a stray 0xA0 as a lock. The 0x80 branch followed by an unrelated write must leave the flag alone and write the array. A design that merged the two branches, or locked on the third step regardless of data, would show the wrong flag at that point. A reset issued five steps into an unlock must stop the sixth step from unlocking. The bench also checks that command writes made while the part is unlocked leave their target bytes at 0xFF, which catches a design that gated array writes on the flag alone.

// File: rtl/eeprom_sdp_pkg.sv
package eeprom_sdp_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] CMD_ADDR_A = 15'h5555;
    localparam logic [ADDR_W-1:0] CMD_ADDR_B = 15'h2AAA;

    localparam logic [DATA_W-1:0] KEY_LEAD   = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] KEY_LOCK   = 8'hA0;
    localparam logic [DATA_W-1:0] KEY_OPEN   = 8'h80;
    localparam logic [DATA_W-1:0] KEY_FINAL  = 8'h20;

    // Detector position: how many steps of a sequence have matched so far.
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_LEAD  = 3'd1,   // first prefix write seen
        SQ_PAIR  = 3'd2,   // shared prefix complete
        SQ_OPEN  = 3'd3,   // unlock branch chosen
        SQ_OLEAD = 3'd4,   // unlock: fourth write seen
        SQ_OPAIR = 3'd5    // unlock: fifth write seen
    } seq_state_t;

    // One bus write as seen by the detector.
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    // Per-write verdict handed from the detector to the flag and array.
    typedef struct packed {
        logic cmd_hit;     // write consumed as a sequence step
        logic do_lock;     // lock sequence completed on this write
        logic do_unlock;   // unlock sequence completed on this write
    } seq_evt_t;

    function automatic logic step_is(input bus_wr_t w,
                                     input logic [ADDR_W-1:0] a,
                                     input logic [DATA_W-1:0] d);
        return w.valid && (w.addr == a) && (w.data == d);
    endfunction

endpackage

// File: rtl/sdp_cmd_fsm.sv
module sdp_cmd_fsm
    import eeprom_sdp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_wr_t  wr,
    output seq_evt_t evt
);

    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        evt     = '0;
        if (wr.valid) begin
            state_d = SQ_IDLE;   // any non-matching write aborts
            unique case (state_q)
                SQ_IDLE: begin
                    if (step_is(wr, CMD_ADDR_A, KEY_LEAD)) begin
                        state_d     = SQ_LEAD;
                        evt.cmd_hit = 1'b1;
                    end
                end
                SQ_LEAD: begin
                    if (step_is(wr, CMD_ADDR_B, KEY_SECOND)) begin
                        state_d     = SQ_PAIR;
                        evt.cmd_hit = 1'b1;
                    end
                end
                SQ_PAIR: begin
                    if (step_is(wr, CMD_ADDR_A, KEY_LOCK)) begin
                        state_d     = SQ_IDLE;
                        evt.cmd_hit = 1'b1;
                        evt.do_lock = 1'b1;
                    end else if (step_is(wr, CMD_ADDR_A, KEY_OPEN)) begin
                        state_d     = SQ_OPEN;
                        evt.cmd_hit = 1'b1;
                    end
                end
                SQ_OPEN: begin
                    if (step_is(wr, CMD_ADDR_A, KEY_LEAD)) begin
                        state_d     = SQ_OLEAD;
                        evt.cmd_hit = 1'b1;
                    end
                end
                SQ_OLEAD: begin
                    if (step_is(wr, CMD_ADDR_B, KEY_SECOND)) begin
                        state_d     = SQ_OPAIR;
                        evt.cmd_hit = 1'b1;
                    end
                end
                SQ_OPAIR: begin
                    if (step_is(wr, CMD_ADDR_A, KEY_FINAL)) begin
                        state_d       = SQ_IDLE;
                        evt.cmd_hit   = 1'b1;
                        evt.do_unlock = 1'b1;
                    end
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/sdp_protect_flag.sv
module sdp_protect_flag
    import eeprom_sdp_pkg::*;
#(
    parameter logic RESET_LOCKED = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  seq_evt_t evt,
    output logic     locked
);

    always_ff @(posedge clk) begin
        if (rst)                locked <= RESET_LOCKED;
        else if (evt.do_lock)   locked <= 1'b1;
        else if (evt.do_unlock) locked <= 1'b0;
    end

endmodule

// File: rtl/sdp_byte_array.sv
module sdp_byte_array
    import eeprom_sdp_pkg::*;
#(
    parameter int              MEM_AW = 6,
    parameter logic [DATA_W-1:0] ERASED = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              cmd_hit,
    input  logic              locked,
    input  logic [MEM_AW-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              arr_we
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Ordinary writes only: not consumed by the detector, and not refused.
    assign arr_we = wr_en && !cmd_hit && !locked;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= ERASED;
            else if (arr_we && (idx == MEM_AW'(g)))
                mem[g] <= wdata;
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/eeprom_sdp_guard.sv
module eeprom_sdp_guard
    import eeprom_sdp_pkg::*;
#(
    parameter int              MEM_AW = 6,
    parameter logic [DATA_W-1:0] ERASED = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              protect_on
);

    bus_wr_t  wr;
    seq_evt_t evt;
    logic     cmd_hit;
    logic     arr_we;

    assign wr.valid = wr_en;
    assign wr.addr  = addr;
    assign wr.data  = wdata;

    sdp_cmd_fsm u_fsm (
        .clk (clk),
        .rst (rst),
        .wr  (wr),
        .evt (evt)
    );

    assign cmd_hit = evt.cmd_hit;

    sdp_protect_flag #(.RESET_LOCKED(1'b1)) u_flag (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .locked (protect_on)
    );

    sdp_byte_array #(.MEM_AW(MEM_AW), .ERASED(ERASED)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .cmd_hit (cmd_hit),
        .locked  (protect_on),
        .idx     (addr[MEM_AW-1:0]),
        .wdata   (wdata),
        .rdata   (rdata),
        .arr_we  (arr_we)
    );

endmodule

// File: rtl/eeprom_sdp_guard_chk.sv
module eeprom_sdp_guard_chk
    import eeprom_sdp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              protect_on,
    input logic              cmd_hit,
    input logic              arr_we
);

    assert_locked_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> protect_on);

    assert_unlock_needs_final_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(protect_on) |-> $past(wr_en && addr == CMD_ADDR_A && wdata == KEY_FINAL));

    assert_lock_needs_key_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(protect_on) |-> $past(wr_en && addr == CMD_ADDR_A && wdata == KEY_LOCK));

    assert_locked_no_store_R4: assert property (@(posedge clk) disable iff (rst)
        protect_on |-> !arr_we);

    assert_cmd_no_store_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_hit |-> !arr_we);

    assert_idle_flag_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(protect_on));

endmodule

bind eeprom_sdp_guard eeprom_sdp_guard_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .protect_on (protect_on),
    .cmd_hit    (cmd_hit),
    .arr_we     (arr_we)
);

// File: tb/eeprom_sdp_guard_tb.sv
`timescale 1ns/1ps
module eeprom_sdp_guard_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [14:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        protect_on;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    eeprom_sdp_guard u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .protect_on (protect_on)
    );

    // Row: {addr[14:0], wdata[7:0], expected flag, expected byte at addr}
    localparam int NV = 13;
    localparam logic [31:0] VEC [NV] = '{
        {15'h0010, 8'h3C, 1'b1, 8'hFF},
        {15'h5555, 8'hAA, 1'b1, 8'hFF},
        {15'h2AAA, 8'h55, 1'b1, 8'hFF},
        {15'h5555, 8'h80, 1'b1, 8'hFF},
        {15'h5555, 8'hAA, 1'b1, 8'hFF},
        {15'h2AAA, 8'h55, 1'b1, 8'hFF},
        {15'h5555, 8'h20, 1'b0, 8'hFF},
        {15'h0010, 8'h3C, 1'b0, 8'h3C},
        {15'h0011, 8'hA5, 1'b0, 8'hA5},
        {15'h5555, 8'hAA, 1'b0, 8'hFF},
        {15'h2AAA, 8'h55, 1'b0, 8'hFF},
        {15'h5555, 8'hA0, 1'b1, 8'hFF},
        {15'h0010, 8'h00, 1'b1, 8'h3C}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [14:0] a, input logic [7:0] exp);
        addr = a;
        #0.5;
        check(tag, rdata, exp);
    endtask

    task automatic flag_chk(input string tag, input logic exp);
        #0.5;
        check(tag, {7'd0, protect_on}, {7'd0, exp});
    endtask

    task automatic unlock_seq();
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h20);
    endtask

    task automatic lock_seq();
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        flag_chk("R1 flag after reset", 1'b1);
        rd_chk("R1 erased byte", 15'h0000, 8'hFF);

        // Table walk: locked write, unlock, open writes, lock, refused write
        for (int i = 0; i < NV; i++) begin
            string ft, dt;
            ft = (i >= 1 && i <= 6) ? "R2 flag" : (i >= 9 && i <= 11) ? "R3 flag" : "R9 flag";
            dt = (i >= 1 && i <= 6) || (i >= 9 && i <= 11) ? "R6 cmd byte" :
                 (i == 0 || i == 12) ? "R4 locked byte" : "R5 open byte";
            wr(VEC[i][31:17], VEC[i][16:9]);
            flag_chk($sformatf("%s row %0d", ft, i), VEC[i][8]);
            rd_chk($sformatf("%s row %0d", dt, i), VEC[i][31:17], VEC[i][7:0]);
        end

        // R2: unlock again
        unlock_seq();
        flag_chk("R2 unlocked", 1'b0);

        // R7: wrong data on step two aborts; write becomes ordinary
        wr(15'h5555, 8'hAA);
        wr(15'h2AAA, 8'h56);
        rd_chk("R7 wrong data stored", 15'h2AAA, 8'h56);
        wr(15'h5555, 8'hA0);
        flag_chk("R7 no lock after abort", 1'b0);
        rd_chk("R7 stray A0 stored", 15'h5555, 8'hA0);

        // R7: repeated lead write is a mismatch
        wr(15'h5555, 8'hAA);
        wr(15'h5555, 8'hAA);
        rd_chk("R7 repeated lead stored", 15'h5555, 8'hAA);
        wr(15'h2AAA, 8'h55);
        rd_chk("R7 second step from idle stored", 15'h2AAA, 8'h55);
        wr(15'h5555, 8'hA0);
        flag_chk("R7 broken lock stays open", 1'b0);
        rd_chk("R7 A0 stored as ordinary", 15'h5555, 8'hA0);

        // R7: wrong address aborts
        wr(15'h5555, 8'hAA);
        wr(15'h2AAB, 8'h55);
        rd_chk("R7 wrong address stored", 15'h2AAB, 8'h55);

        // R8: unlock branch then unrelated write
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        flag_chk("R8 branch keeps flag", 1'b0);
        rd_chk("R6 branch step not stored", 15'h5555, 8'hA0);
        wr(15'h0020, 8'h77);
        flag_chk("R8 abort keeps flag", 1'b0);
        rd_chk("R8 abort write stored", 15'h0020, 8'h77);

        // R9 / R10: strobe low, data wiggling; aliasing read
        @(negedge clk); addr = 15'h0011; wdata = 8'h00;
        @(negedge clk); wdata = 8'h5A;
        @(negedge clk);
        rd_chk("R9 no write without strobe", 15'h0011, 8'hA5);
        flag_chk("R9 flag idle", 1'b0);
        rd_chk("R10 alias read", 15'h4010, 8'h3C);

        // R3 / R4: lock, refused write
        lock_seq();
        flag_chk("R3 locked", 1'b1);
        wr(15'h0011, 8'h00);
        rd_chk("R4 refused write", 15'h0011, 8'hA5);

        // R1: reset clears a partial unlock
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_chk("R1 array erased by reset", 15'h0010, 8'hFF);
        wr(15'h5555, 8'h20);
        flag_chk("R1 sequence cleared by reset", 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule